// File: doc/BRIEF.md
# Adaptive Mesh Route Computation Unit

This block sits on one input port of a two-dimensional mesh router. When a head flit arrives, it records the packet's destination coordinates and virtual-channel class. From then on, in every cycle, it works out which output port and which output virtual channel the packet should request. The inputs to that choice are the router's own coordinates and the live free and credit status of every output virtual channel. The choice is never latched on arrival. Each cycle's request uses the status of that cycle, and this repeats until the virtual-channel allocator grants it.

Each physical channel carries one escape virtual channel (VC0) and one or more adaptive ones. An adaptive candidate may use any productive direction, and the free adaptive channel with the most credits wins. The escape channel follows X-then-Y dimension order, which keeps the scheme deadlock-free. By default a packet that arrived on the escape class may move back to an adaptive channel whenever one is free. Once the allocator grants a request, the port and channel are frozen. Body and tail flits then follow them without recomputation until the tail flit has passed.

Top module: `mesh_route_unit`

## Requirements
- R1: After reset, `req_valid` and `route_active` are both 0.
- R2: A valid request names a port that reduces the Manhattan distance to the destination. The encoding is 0 local, 1 east (+x), 2 west (−x), 3 north (+y), 4 south (−y). The local port is requested exactly when the destination equals the router's coordinates. A port leading off the mesh is never requested.
- R3: The requested output channel is free in that cycle. Free bit `p*NUM_VC+v` and credit field `(p*NUM_VC+v)*CRED_W` describe port `p`, channel `v`.
- R4: When at least one adaptive channel (index ≥ 1) on a productive direction is free, the request goes to the one with the highest credit count. A credit tie between the X and Y directions goes to X. A tie between channels of one port goes to the lower index.
- R5: When no such adaptive channel is free, the request goes to channel 0 on the X-first dimension-order port. If that channel is busy, `req_valid` is 0 in that cycle.
- R6: While a head is pending, the request is recomputed every cycle from the current status, with no further flit.
- R7: With the default `STICKY_ESCAPE=0`, a packet whose input channel is 0 (escape class) may still be given an adaptive channel. With `STICKY_ESCAPE=1`, such a packet requests channel 0 only.
- R8: `grant` has effect only in a cycle where `req_valid` is 1.
- R9: After a grant, `route_active` is 1 and `route_port`/`route_vc` hold the granted values unchanged, with no request. This lasts until a flit with `flit_tail` set passes. Head flits that arrive meanwhile are ignored.
- R10: A head flit that also carries `flit_tail` (single-flit packet) returns the unit to idle on its grant, without raising `route_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flit_valid | input | 1 | A flit is present on the input this cycle |
| flit_head | input | 1 | The flit is a head flit |
| flit_tail | input | 1 | The flit is a tail flit (may be set together with head) |
| in_vc | input | VCW | Input virtual channel of the packet (0 = escape class) |
| dest_x | input | XW | Destination column, taken from the head flit |
| dest_y | input | YW | Destination row, taken from the head flit |
| here_x | input | XW | This router's column |
| here_y | input | YW | This router's row |
| vc_free | input | NPORT*NUM_VC | Output channel free flags |
| vc_credit | input | NPORT*NUM_VC*CRED_W | Output channel credit counts |
| grant | input | 1 | Allocator grants the current request |
| req_valid | output | 1 | A request is presented this cycle |
| req_port | output | 3 | Requested output port |
| req_vc | output | VCW | Requested output channel |
| route_active | output | 1 | A granted route is held for body and tail flits |
| route_port | output | 3 | Held output port |
| route_vc | output | VCW | Held output channel |

## Verification
The bound checker checks the following on every cycle:
- Every request is minimal, never leaves the mesh and picks a channel that is free.
- An escape request moves in X while X is still unresolved.
- A held route never changes while it stays active, and no request is made while it is held.
- A grant with no request never activates a route, and a single-flit grant returns to idle.

Only the bench's scenarios can show the following:
- Which candidate wins: the credit comparison, the tie going to X, and the fall-back to the escape channel.
- That the request follows a status change with no new flit.
- That an escape-class packet is handed an adaptive channel.
- That stray head flits during a held route and the tail release behave as specified.

// File: rtl/mru_pkg.sv
// Shared types for the mesh route unit.
package mru_pkg;
    // Output port encoding; neighbours decode these values.
    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;

    localparam int NPORT = 5;
endpackage

// File: rtl/mru_dirs.sv
// Productive-direction finder.
// Works out the productive X slot and Y slot and the X-first
// dimension-order port. At the destination the X slot carries the local port.
// Assumes the destination lies inside the mesh.
module mru_dirs
    import mru_pkg::*;
#(
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic [XW-1:0] here_x,
    input  logic [YW-1:0] here_y,
    input  logic [XW-1:0] dest_x,
    input  logic [YW-1:0] dest_y,
    output logic          xslot_ok,
    output port_e         xslot_port,
    output logic          yslot_ok,
    output port_e         yslot_port,
    output port_e         xy_port
);
    // X slot: east/west when columns differ, local when already home.
    always_comb begin
        xslot_ok   = 1'b1;
        xslot_port = PORT_LOCAL;
        if (dest_x > here_x) begin
            xslot_port = PORT_EAST;
        end else if (dest_x < here_x) begin
            xslot_port = PORT_WEST;
        end else if (dest_y != here_y) begin
            xslot_ok = 1'b0;
        end
    end

    // Y slot: north/south when rows differ.
    always_comb begin
        yslot_ok   = (dest_y != here_y);
        yslot_port = (dest_y > here_y) ? PORT_NORTH : PORT_SOUTH;
    end

    // Dimension-order port for the escape class: resolve X before Y.
    always_comb begin
        if (dest_x != here_x) begin
            xy_port = xslot_port;
        end else if (dest_y != here_y) begin
            xy_port = yslot_port;
        end else begin
            xy_port = PORT_LOCAL;
        end
    end
endmodule

// File: rtl/mru_vc_best.sv
// Best adaptive channel on one port.
// Scans channels 1..NUM_VC-1 of the given port and returns the free one
// with the most credits; ties go to the lower index.
// Assumes slot_port < NPORT whenever slot_ok is set.
module mru_vc_best
    import mru_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int CRED_W = 4,
    parameter int VCW    = 1
) (
    input  logic              slot_ok,
    input  port_e             slot_port,
    input  logic [NUM_VC-1:0] free_a [NPORT],
    input  logic [CRED_W-1:0] cred_a [NPORT][NUM_VC],
    output logic              found,
    output logic [VCW-1:0]    best_vc,
    output logic [CRED_W-1:0] best_cred
);
    // Linear scan keeping the strictly larger credit count.
    always_comb begin
        found     = 1'b0;
        best_vc   = '0;
        best_cred = '0;
        for (int v = 1; v < NUM_VC; v++) begin
            if (slot_ok && free_a[slot_port][VCW'(v)] &&
                (!found || cred_a[slot_port][VCW'(v)] > best_cred)) begin
                found     = 1'b1;
                best_vc   = VCW'(v);
                best_cred = cred_a[slot_port][VCW'(v)];
            end
        end
    end
endmodule

// File: rtl/mru_select.sv
// Request chooser.
// Takes the two adaptive candidates and applies the credit comparison
// (X wins ties), then falls back to escape channel 0 on the dimension-order
// port. STICKY_ESCAPE=1 keeps escape-class packets off the adaptive channels.
module mru_select
    import mru_pkg::*;
#(
    parameter int CRED_W        = 4,
    parameter int VCW           = 1,
    parameter bit STICKY_ESCAPE = 1'b0
) (
    input  logic              x_found,
    input  port_e             x_port,
    input  logic [VCW-1:0]    x_vc,
    input  logic [CRED_W-1:0] x_cred,
    input  logic              y_found,
    input  port_e             y_port,
    input  logic [VCW-1:0]    y_vc,
    input  logic [CRED_W-1:0] y_cred,
    input  port_e             xy_port,
    input  logic [NPORT-1:0]  esc_free,
    input  logic              in_escape,
    output logic              sel_valid,
    output port_e             sel_port,
    output logic [VCW-1:0]    sel_vc
);
    logic adapt_ok;

    // Parameter picks whether escape-class packets may return to adaptive.
    generate
        if (STICKY_ESCAPE) begin : g_sticky
            assign adapt_ok = !in_escape;
        end else begin : g_free
            assign adapt_ok = 1'b1 | in_escape;
        end
    endgenerate

    // Priority: best adaptive (X on tie), then escape on XY port, else none.
    always_comb begin
        sel_valid = 1'b0;
        sel_port  = xy_port;
        sel_vc    = '0;
        if (adapt_ok && x_found && (!y_found || x_cred >= y_cred)) begin
            sel_valid = 1'b1;
            sel_port  = x_port;
            sel_vc    = x_vc;
        end else if (adapt_ok && y_found) begin
            sel_valid = 1'b1;
            sel_port  = y_port;
            sel_vc    = y_vc;
        end else if (esc_free[xy_port]) begin
            sel_valid = 1'b1;
        end
    end
endmodule

// File: rtl/mru_hold.sv
// Packet state holder.
// Captures the head flit's destination and class, and keeps the pending
// flag until a grant. It then freezes the granted port and channel until the
// tail flit passes. Heads arriving while pending or held are dropped.
module mru_hold
    import mru_pkg::*;
#(
    parameter int XW  = 2,
    parameter int YW  = 2,
    parameter int VCW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flit_valid,
    input  logic           flit_head,
    input  logic           flit_tail,
    input  logic [VCW-1:0] in_vc,
    input  logic [XW-1:0]  dest_x,
    input  logic [YW-1:0]  dest_y,
    input  logic           sel_valid,
    input  port_e          sel_port,
    input  logic [VCW-1:0] sel_vc,
    input  logic           grant,
    output logic           head_pending,
    output logic           pkt_locked,
    output logic           pkt_single,
    output logic           pkt_escape,
    output logic [XW-1:0]  held_dx,
    output logic [YW-1:0]  held_dy,
    output port_e          fwd_port,
    output logic [VCW-1:0] fwd_vc
);
    logic take_head, take_grant, take_tail;

    // Event decode for the three state transitions.
    always_comb begin
        take_head  = !head_pending && !pkt_locked && flit_valid && flit_head;
        take_grant = head_pending && sel_valid && grant;
        take_tail  = pkt_locked && flit_valid && flit_tail;
    end

    // State update: idle -> pending -> held -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_pending <= 1'b0;
            pkt_locked   <= 1'b0;
            pkt_single   <= 1'b0;
            pkt_escape   <= 1'b0;
            held_dx      <= '0;
            held_dy      <= '0;
            fwd_port     <= PORT_LOCAL;
            fwd_vc       <= '0;
        end else if (take_head) begin
            head_pending <= 1'b1;
            pkt_single   <= flit_tail;
            pkt_escape   <= (in_vc == '0);
            held_dx      <= dest_x;
            held_dy      <= dest_y;
        end else if (take_grant) begin
            head_pending <= 1'b0;
            pkt_locked   <= !pkt_single;
            fwd_port     <= sel_port;
            fwd_vc       <= sel_vc;
        end else if (take_tail) begin
            pkt_locked   <= 1'b0;
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
// Adaptive mesh route computation unit (top).
// One instance serves one router input port. It recomputes the output
// request every cycle while a head waits, then holds the granted route.
// Assumes coordinates lie inside a MESH_X x MESH_Y mesh and NUM_VC >= 2.
module mesh_route_unit
    import mru_pkg::*;
#(
    parameter int MESH_X        = 4,
    parameter int MESH_Y        = 4,
    parameter int NUM_VC        = 2,
    parameter int CRED_W        = 4,
    parameter bit STICKY_ESCAPE = 1'b0,
    localparam int XW  = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW  = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
    localparam int VCW = $clog2(NUM_VC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flit_valid,
    input  logic                           flit_head,
    input  logic                           flit_tail,
    input  logic [VCW-1:0]                 in_vc,
    input  logic [XW-1:0]                  dest_x,
    input  logic [YW-1:0]                  dest_y,
    input  logic [XW-1:0]                  here_x,
    input  logic [YW-1:0]                  here_y,
    input  logic [NPORT*NUM_VC-1:0]        vc_free,
    input  logic [NPORT*NUM_VC*CRED_W-1:0] vc_credit,
    input  logic                           grant,
    output logic                           req_valid,
    output logic [2:0]                     req_port,
    output logic [VCW-1:0]                 req_vc,
    output logic                           route_active,
    output logic [2:0]                     route_port,
    output logic [VCW-1:0]                 route_vc
);
    logic [NUM_VC-1:0] free_a [NPORT];
    logic [CRED_W-1:0] cred_a [NPORT][NUM_VC];
    logic [NPORT-1:0]  esc_free;

    // Unpack the flat status vectors into per-port, per-channel views.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign free_a[p]   = vc_free[p*NUM_VC +: NUM_VC];
        assign esc_free[p] = vc_free[p*NUM_VC];
        for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
            assign cred_a[p][v] = vc_credit[(p*NUM_VC+v)*CRED_W +: CRED_W];
        end
    end

    logic           head_pending, pkt_locked, pkt_single, pkt_escape;
    logic [XW-1:0]  held_dx;
    logic [YW-1:0]  held_dy;
    port_e          fwd_port;
    logic [VCW-1:0] fwd_vc;

    logic  xslot_ok, yslot_ok;
    port_e xslot_port, yslot_port, xy_port;

    mru_dirs #(.XW(XW), .YW(YW)) dirs_i (
        .here_x(here_x), .here_y(here_y), .dest_x(held_dx), .dest_y(held_dy),
        .xslot_ok(xslot_ok), .xslot_port(xslot_port),
        .yslot_ok(yslot_ok), .yslot_port(yslot_port), .xy_port(xy_port)
    );

    logic              x_found, y_found;
    logic [VCW-1:0]    x_vc, y_vc;
    logic [CRED_W-1:0] x_cred, y_cred;

    mru_vc_best #(.NUM_VC(NUM_VC), .CRED_W(CRED_W), .VCW(VCW)) xbest_i (
        .slot_ok(xslot_ok), .slot_port(xslot_port), .free_a(free_a),
        .cred_a(cred_a), .found(x_found), .best_vc(x_vc), .best_cred(x_cred)
    );

    mru_vc_best #(.NUM_VC(NUM_VC), .CRED_W(CRED_W), .VCW(VCW)) ybest_i (
        .slot_ok(yslot_ok), .slot_port(yslot_port), .free_a(free_a),
        .cred_a(cred_a), .found(y_found), .best_vc(y_vc), .best_cred(y_cred)
    );

    logic           sel_valid;
    port_e          sel_port;
    logic [VCW-1:0] sel_vc;

    mru_select #(.CRED_W(CRED_W), .VCW(VCW), .STICKY_ESCAPE(STICKY_ESCAPE)) sel_i (
        .x_found(x_found), .x_port(xslot_port), .x_vc(x_vc), .x_cred(x_cred),
        .y_found(y_found), .y_port(yslot_port), .y_vc(y_vc), .y_cred(y_cred),
        .xy_port(xy_port), .esc_free(esc_free), .in_escape(pkt_escape),
        .sel_valid(sel_valid), .sel_port(sel_port), .sel_vc(sel_vc)
    );

    mru_hold #(.XW(XW), .YW(YW), .VCW(VCW)) hold_i (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .flit_tail(flit_tail), .in_vc(in_vc), .dest_x(dest_x), .dest_y(dest_y),
        .sel_valid(sel_valid), .sel_port(sel_port), .sel_vc(sel_vc), .grant(grant),
        .head_pending(head_pending), .pkt_locked(pkt_locked), .pkt_single(pkt_single),
        .pkt_escape(pkt_escape), .held_dx(held_dx), .held_dy(held_dy),
        .fwd_port(fwd_port), .fwd_vc(fwd_vc)
    );

    // Output drive: request only while a head is pending.
    always_comb begin
        req_valid    = head_pending && sel_valid;
        req_port     = sel_port;
        req_vc       = sel_vc;
        route_active = pkt_locked;
        route_port   = fwd_port;
        route_vc     = fwd_vc;
    end
endmodule

// File: rtl/mesh_route_unit_chk.sv
// Property checker for mesh_route_unit, attached by bind.
// Checks minimality, channel freedom, escape ordering, hold stability and
// grant qualification on every cycle.
module mesh_route_unit_chk
    import mru_pkg::*;
#(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int NUM_VC = 2,
    parameter int XW     = 2,
    parameter int YW     = 2,
    parameter int VCW    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant,
    input logic              req_valid,
    input logic [2:0]        req_port,
    input logic [VCW-1:0]    req_vc,
    input logic              route_active,
    input logic [2:0]        route_port,
    input logic [VCW-1:0]    route_vc,
    input logic [XW-1:0]     here_x,
    input logic [YW-1:0]     here_y,
    input logic [XW-1:0]     held_dx,
    input logic [YW-1:0]     held_dy,
    input logic              head_pending,
    input logic              pkt_single,
    input logic [NUM_VC-1:0] free_a [NPORT]
);
    // R1: reset leaves no request and no held route
    p_idle_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!req_valid && !route_active));

    // R2: each requested port is productive and stays on the mesh
    p_minimal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |->
            ((req_port != PORT_EAST)  || (held_dx > here_x && here_x != XW'(MESH_X-1))) &&
            ((req_port != PORT_WEST)  || (held_dx < here_x && here_x != '0)) &&
            ((req_port != PORT_NORTH) || (held_dy > here_y && here_y != YW'(MESH_Y-1))) &&
            ((req_port != PORT_SOUTH) || (held_dy < here_y && here_y != '0)) &&
            ((req_port != PORT_LOCAL) || (held_dx == here_x && held_dy == here_y)) &&
            (req_port <= 3'd4));

    // R3: the requested channel is free this cycle
    p_chan_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> free_a[req_port][req_vc]);

    // R5: escape requests resolve X first
    p_escape_xfirst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vc == '0 && held_dx != here_x) |->
            (req_port == PORT_EAST || req_port == PORT_WEST));

    // R8: a grant without a request cannot start a held route
    p_grant_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !route_active) |=> !route_active);

    // R9: a held route does not move while it remains active
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        route_active |=> (!route_active || ($stable(route_port) && $stable(route_vc))));

    // R9: no request while a route is held
    p_no_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        route_active |-> !req_valid);

    // R10: a single-flit grant returns straight to idle
    p_single_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && grant && pkt_single) |=> (!route_active && !head_pending));
endmodule

bind mesh_route_unit mesh_route_unit_chk #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .NUM_VC(NUM_VC),
    .XW(XW), .YW(YW), .VCW(VCW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_valid(req_valid),
    .req_port(req_port), .req_vc(req_vc), .route_active(route_active),
    .route_port(route_port), .route_vc(route_vc), .here_x(here_x),
    .here_y(here_y), .held_dx(held_dx), .held_dy(held_dy),
    .head_pending(head_pending), .pkt_single(pkt_single), .free_a(free_a)
);

// File: tb/mesh_route_unit_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for mesh_route_unit (default 4x4 mesh, 2 channels).
module mesh_route_unit_tb_top;
    localparam int NP = 5, NV = 2, CW = 4;
    localparam int LOC = 0, EA = 1, WE = 2, NO = 3, SO = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic flit_valid = 0, flit_head = 0, flit_tail = 0, grant = 0;
    logic [0:0] in_vc = '0;
    logic [1:0] dest_x = '0, dest_y = '0, here_x = '0, here_y = '0;
    logic [NP*NV-1:0] vc_free = '0;
    logic [NP*NV*CW-1:0] vc_credit = '0;
    logic req_valid, route_active;
    logic [2:0] req_port, route_port;
    logic [0:0] req_vc, route_vc;

    always #2.5 clk = ~clk;   // 200 MHz

    mesh_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .flit_tail(flit_tail), .in_vc(in_vc), .dest_x(dest_x), .dest_y(dest_y),
        .here_x(here_x), .here_y(here_y), .vc_free(vc_free), .vc_credit(vc_credit),
        .grant(grant), .req_valid(req_valid), .req_port(req_port), .req_vc(req_vc),
        .route_active(route_active), .route_port(route_port), .route_vc(route_vc)
    );

    int total = 0, bad = 0;
    bit fm [NP][NV];
    int cm [NP][NV];

    typedef struct {
        int    kind;   // 0 request, 1 held route
        int    valid;
        int    port;
        int    vc;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string tag, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Monitor: pop one expectation per falling edge and compare.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.kind == 0) begin
                if (e.valid == 0)
                    chk(req_valid == 1'b0, e.tag,
                        $sformatf("req_valid=%0d expected 0", req_valid));
                else
                    chk(req_valid && req_port == e.port && req_vc == e.vc, e.tag,
                        $sformatf("req v/p/c=%0d/%0d/%0d expected 1/%0d/%0d",
                                  req_valid, req_port, req_vc, e.port, e.vc));
            end else begin
                chk(route_active == e.valid[0] && !req_valid &&
                    (e.valid == 0 || (route_port == e.port && route_vc == e.vc)), e.tag,
                    $sformatf("active/p/c/req=%0d/%0d/%0d/%0d expected %0d/%0d/%0d/0",
                              route_active, route_port, route_vc, req_valid,
                              e.valid, e.port, e.vc));
            end
        end
    end

    // Driver: queue an expectation and let the monitor consume it.
    task automatic expect_item(input int kind, input int v, input int p,
                               input int c, input string tag);
        exp_t e;
        e.kind = kind; e.valid = v; e.port = p; e.vc = c; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk); #0.5;
    endtask

    task automatic apply_status();
        for (int p = 0; p < NP; p++)
            for (int v = 0; v < NV; v++) begin
                vc_free[p*NV+v] = fm[p][v];
                vc_credit[(p*NV+v)*CW +: CW] = cm[p][v][CW-1:0];
            end
    endtask

    task automatic clear_status();
        for (int p = 0; p < NP; p++)
            for (int v = 0; v < NV; v++) begin
                fm[p][v] = 0; cm[p][v] = 0;
            end
        apply_status();
    endtask

    task automatic set_vc(input int p, input int v, input bit f, input int c);
        fm[p][v] = f; cm[p][v] = c;
        apply_status();
    endtask

    task automatic send_flit(input bit h, input bit t, input int dx,
                             input int dy, input int ivc);
        @(posedge clk); #1;
        flit_valid = 1; flit_head = h; flit_tail = t;
        dest_x = dx[1:0]; dest_y = dy[1:0]; in_vc = ivc[0:0];
        @(posedge clk); #1;
        flit_valid = 0; flit_head = 0; flit_tail = 0;
    endtask

    task automatic pulse_grant();
        @(posedge clk); #1; grant = 1;
        @(posedge clk); #1; grant = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 0;
        @(posedge clk); #1; @(posedge clk); #1; rst_n = 1;
    endtask

    function automatic int xy_dir(input int hx, input int hy, input int dx, input int dy);
        if (dx > hx) return EA;
        if (dx < hx) return WE;
        if (dy > hy) return NO;
        if (dy < hy) return SO;
        return LOC;
    endfunction

    function automatic int absd(input int a);
        return (a < 0) ? -a : a;
    endfunction

    // Sweep all destinations from one node under a status pattern.
    task automatic sweep(input int hx, input int hy, input int pat);
        here_x = hx[1:0]; here_y = hy[1:0];
        for (int dx = 0; dx < 4; dx++)
            for (int dy = 0; dy < 4; dy++) begin
                int d0, nx, ny, d1, p, c;
                for (int pp = 0; pp < NP; pp++)
                    for (int vv = 0; vv < NV; vv++) begin
                        if (pat == 0) begin
                            fm[pp][vv] = 1; cm[pp][vv] = (pp*3 + vv*7 + dx + dy) % 16;
                        end else if (pat == 1) begin
                            fm[pp][vv] = (vv == 0); cm[pp][vv] = 5;
                        end else begin
                            fm[pp][vv] = (vv == 0) || pp == WE || pp == NO; cm[pp][vv] = 4;
                        end
                    end
                apply_status();
                send_flit(1, 1, dx, dy, (dx + dy) % 2);
                @(negedge clk); #0.5;
                p = req_port; c = req_vc;
                d0 = absd(dx - hx) + absd(dy - hy);
                nx = hx + (p == EA) - (p == WE);
                ny = hy + (p == NO) - (p == SO);
                d1 = absd(dx - nx) + absd(dy - ny);
                chk(req_valid == 1'b1, "R5", $sformatf("sweep req_valid=%0d expected 1", req_valid));
                chk((d0 == 0) ? (p == LOC) : (p != LOC && p <= 4 && d1 < d0 &&
                    nx >= 0 && nx < 4 && ny >= 0 && ny < 4), "R2",
                    $sformatf("from (%0d,%0d) to (%0d,%0d) port=%0d dist %0d->%0d expected shorter",
                              hx, hy, dx, dy, p, d0, d1));
                chk(p <= 4 && fm[p][c], "R3",
                    $sformatf("port %0d vc %0d free=0 expected 1", p, c));
                if (pat == 0)
                    chk(c != 0, "R7", $sformatf("vc=%0d expected adaptive 1", c));
                else if (pat == 1)
                    chk(c == 0 && p == xy_dir(hx, hy, dx, dy), "R5",
                        $sformatf("port/vc=%0d/%0d expected %0d/0", p, c, xy_dir(hx, hy, dx, dy)));
                else begin
                    int ep, ev;
                    if (dx < hx) begin ep = WE; ev = 1; end
                    else if (dy > hy) begin ep = NO; ev = 1; end
                    else begin ep = xy_dir(hx, hy, dx, dy); ev = 0; end
                    chk(p == ep && c == ev, "R4",
                        $sformatf("port/vc=%0d/%0d expected %0d/%0d", p, c, ep, ev));
                end
                if (req_valid) pulse_grant(); else do_reset();
            end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_status();
        here_x = 2'd1; here_y = 2'd2;
        do_reset();
        // R1: reset state
        expect_item(0, 0, 0, 0, "R1");
        expect_item(1, 0, 0, 0, "R1");

        // Head to (3,0): productive east and south; nothing free -> no request (R5)
        send_flit(1, 0, 3, 0, 1);
        expect_item(0, 0, 0, 0, "R5 all busy");
        // R6: status change alone yields a request; south has more credit (R4)
        set_vc(EA, 1, 1, 3); set_vc(SO, 1, 1, 5);
        expect_item(0, 1, SO, 1, "R6 recompute / R4 credit");
        // R4: equal credits -> X direction wins
        set_vc(EA, 1, 1, 5);
        expect_item(0, 1, EA, 1, "R4 tie to X");
        // R5: adaptive busy -> escape on XY port (east before south)
        set_vc(EA, 1, 0, 5); set_vc(SO, 1, 0, 5);
        set_vc(EA, 0, 1, 2); set_vc(SO, 0, 1, 9);
        expect_item(0, 1, EA, 0, "R5 XY escape");
        // R9: grant freezes east/0
        pulse_grant();
        expect_item(1, 1, EA, 0, "R9 grant held");
        set_vc(SO, 1, 1, 15); set_vc(EA, 0, 0, 0);
        expect_item(1, 1, EA, 0, "R9 status change ignored");
        send_flit(1, 0, 1, 2, 1);
        expect_item(1, 1, EA, 0, "R9 head while held ignored");
        send_flit(0, 0, 0, 0, 1);
        expect_item(1, 1, EA, 0, "R9 body flit keeps route");
        send_flit(0, 1, 0, 0, 1);
        expect_item(1, 0, 0, 0, "R9 tail releases");

        // R8: grant without request is ignored; local destination (R2)
        clear_status();
        send_flit(1, 1, 1, 2, 1);
        expect_item(0, 0, 0, 0, "R8 no request");
        pulse_grant();
        expect_item(1, 0, 0, 0, "R8 grant ignored");
        set_vc(LOC, 1, 1, 1);
        expect_item(0, 1, LOC, 1, "R8 still pending / R2 local");
        // R10: single-flit grant returns to idle
        pulse_grant();
        expect_item(1, 0, 0, 0, "R10 single idle");

        // R7: escape-class packet to (0,3) gets adaptive west
        clear_status();
        set_vc(WE, 0, 1, 9); set_vc(WE, 1, 1, 2);
        send_flit(1, 1, 0, 3, 0);
        expect_item(0, 1, WE, 1, "R7 escape to adaptive");
        // R4: north gets more credits -> north adaptive
        set_vc(NO, 1, 1, 8);
        expect_item(0, 1, NO, 1, "R4 higher credit Y");
        pulse_grant();
        expect_item(1, 0, 0, 0, "R10 single idle again");

        // R2/R3/R4/R5/R7: destination sweeps from an interior node and an edge node
        for (int pat = 0; pat < 3; pat++) begin
            sweep(1, 2, pat);
            sweep(3, 0, pat);
        end

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule